// File: doc/BRIEF.md
# Multi-Lane Alignment Marker Inserter

This block sits in a transmit datapath that carries 64-bit PCS words. The words are dealt out round-robin over twenty virtual lanes. At a fixed interval the block stops taking data and sends a burst of twenty 64-bit alignment markers, one for each lane. Lane 0's marker goes first and the others follow in ascending lane order. While the burst is on the wire, upstream is held off through the input handshake. When the burst ends, data flows again starting on lane 0.

The interval is programmed as a minus-one value P. Each lane carries P data words between two markers, so every lane sees a marker once every P+1 of its own words. Each lane's marker value is programmed separately. The period and marker inputs are copied into an active set only when a burst completes, so changes made in the middle of an interval wait for the next boundary. The block has no storage on its datapath: output valid, output data and input ready are combinational, and the only state is the phase, the lane position, the round count and the active configuration.

Top module: `am_inserter`

## Requirements
- R1: The first output after reset is a marker burst, ahead of any data. The active period resets to 16383. The lane 0 marker resets to 64'hc16821003e97de00 and the lane 1 marker resets to 64'h9d718e00628e7100. Lanes 2 to 19 reset to fixed values that are distinct and nonzero.
- R2: A burst is exactly 20 output words with out_valid_o high. The word for lane k is the active marker of lane k, for k = 0 to 19 in ascending order.
- R3: in_ready_o is low for every cycle of a burst, so no input word is consumed during a burst.
- R4: Between two bursts exactly P*20 input words pass through to the output unchanged and in order, where P is the active period.
- R5: In the data phase out_valid_o equals in_valid_i, out_data_o equals in_data_i and in_ready_o equals out_ready_i.
- R6: A word advances only when out_valid_o and out_ready_i are both high. A burst marker that is blocked stays on out_data_o unchanged.
- R7: period_m1_i and markers_i are copied into the active set in the cycle that the lane 19 marker is accepted. Any other value these inputs hold has no effect on the output.
- R8: With an active period of 0, bursts follow one another back to back with no data words between them.
- R9: The markers_i bus is packed with lane k in bits [64k+63:64k].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| period_m1_i | input | 16 | Data words per lane between markers; the per-lane marker interval minus one |
| markers_i | input | 1280 | Marker value for each lane, lane k in bits [64k+63:64k] |
| in_valid_i | input | 1 | Input word valid |
| in_data_i | input | 64 | Input PCS word |
| in_ready_o | output | 1 | Input word accepted when high together with in_valid_i |
| out_valid_o | output | 1 | Output word valid |
| out_data_o | output | 64 | Output PCS word or marker |
| out_ready_i | input | 1 | Downstream ready |

## Verification
A wrong lane count or round count shows at the ports as a burst that begins too early or too late. It appears within one interval of P*20 data words, as a marker where a data word was expected or the other way round. A lane index that slips inside a burst puts the wrong marker value on out_data_o straight away. If the capture of the active set happens at the wrong moment, a changed period or marker appears one burst too early, which shows on the first boundary after the inputs change. Backpressure faults show in the same cycle as a marker that changes while out_ready_i is low.

// File: rtl/am_pkg.sv
package am_pkg;
  localparam int unsigned NUM_LANES  = 20;
  localparam int unsigned WORD_W     = 64;
  localparam int unsigned PER_W      = 16;
  localparam logic [PER_W-1:0] PERIOD_RST = 16'h3FFF;

  function automatic logic [WORD_W-1:0] default_marker(input int unsigned lane);
    case (lane)
      0:  default_marker = 64'hc16821003e97de00;
      1:  default_marker = 64'h9d718e00628e7100;
      2:  default_marker = 64'h594be800a6b41700;
      3:  default_marker = 64'h4d957b00b26a8400;
      4:  default_marker = 64'hf50709000af8f600;
      5:  default_marker = 64'hdd14c20022eb3d00;
      6:  default_marker = 64'h9a4a260065b5d900;
      7:  default_marker = 64'h7b45660084ba9900;
      8:  default_marker = 64'ha02476005fdb8900;
      9:  default_marker = 64'h68c9fb0097360400;
      10: default_marker = 64'hfd6c990002936600;
      11: default_marker = 64'hb9915500466eaa00;
      12: default_marker = 64'h5cb9b200a3464d00;
      13: default_marker = 64'h1af8bd00e5074200;
      14: default_marker = 64'h83c7ca007c383500;
      15: default_marker = 64'h3536cd00cac93200;
      16: default_marker = 64'hc4314c003bceb300;
      17: default_marker = 64'hadd6b70052294800;
      18: default_marker = 64'h5f662a00a099d500;
      19: default_marker = 64'hc0f0e5003f0f1a00;
      default: default_marker = 64'h0;
    endcase
  endfunction
endpackage

// File: rtl/am_lane_seq.sv
module am_lane_seq #(
  parameter int unsigned LANES  = am_pkg::NUM_LANES,
  parameter int unsigned PER_W  = am_pkg::PER_W,
  localparam int unsigned LANE_W = $clog2(LANES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  logic [PER_W-1:0]  period_m1_i,
  output logic              burst_o,
  output logic              cap_o,
  output logic [LANE_W-1:0] lane_o
);
  localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(LANES - 1);

  logic              burst_q;
  logic [LANE_W-1:0] lane_q;
  logic [PER_W-1:0]  rnd_q;
  logic [PER_W-1:0]  per_q;
  logic              last_lane;

  assign last_lane = (lane_q == LAST_LANE);
  assign cap_o     = burst_q && fire_i && last_lane;
  assign burst_o   = burst_q;
  assign lane_o    = lane_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      burst_q <= 1'b1;
      lane_q  <= '0;
      rnd_q   <= '0;
      per_q   <= am_pkg::PERIOD_RST;
    end else if (fire_i) begin
      if (burst_q) begin
        if (last_lane) begin
          // boundary: latch the next interval's period
          per_q   <= period_m1_i;
          lane_q  <= '0;
          rnd_q   <= '0;
          burst_q <= (period_m1_i == '0);
        end else begin
          lane_q <= lane_q + LANE_W'(1);
        end
      end else if (last_lane) begin
        lane_q <= '0;
        if (rnd_q == per_q - PER_W'(1)) begin
          rnd_q   <= '0;
          burst_q <= 1'b1;
        end else begin
          rnd_q <= rnd_q + PER_W'(1);
        end
      end else begin
        lane_q <= lane_q + LANE_W'(1);
      end
    end
  end

  p_lane_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lane_q <= LAST_LANE);
  p_burst_from_lane0_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(burst_q) |-> lane_q == '0);
  p_no_move_on_stall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire_i |=> $stable(lane_q) && $stable(burst_q) && $stable(rnd_q));
  p_period_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_o |=> $stable(per_q));
  p_zero_period_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_o && period_m1_i == '0 |=> burst_q && lane_q == '0);
endmodule

// File: rtl/am_marker_bank.sv
module am_marker_bank #(
  parameter int unsigned LANES  = am_pkg::NUM_LANES,
  parameter int unsigned WORD_W = am_pkg::WORD_W,
  localparam int unsigned LANE_W = $clog2(LANES)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cap_i,
  input  logic [LANES*WORD_W-1:0] markers_i,
  input  logic [LANE_W-1:0]       lane_i,
  output logic [WORD_W-1:0]       marker_o
);
  logic [WORD_W-1:0] act_q [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    act_q[g] <= am_pkg::default_marker(g);
      else if (cap_i) act_q[g] <= markers_i[g*WORD_W +: WORD_W];
    end
    p_marker_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cap_i |=> $stable(act_q[g]));
  end

  always_comb begin
    marker_o = '0;
    for (int i = 0; i < LANES; i++)
      if (lane_i == LANE_W'(i)) marker_o = act_q[i];
  end
endmodule

// File: rtl/am_inserter.sv
module am_inserter #(
  parameter int unsigned LANES  = am_pkg::NUM_LANES,
  parameter int unsigned WORD_W = am_pkg::WORD_W,
  parameter int unsigned PER_W  = am_pkg::PER_W,
  localparam int unsigned LANE_W = $clog2(LANES)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [PER_W-1:0]        period_m1_i,
  input  logic [LANES*WORD_W-1:0] markers_i,
  input  logic                    in_valid_i,
  input  logic [WORD_W-1:0]       in_data_i,
  output logic                    in_ready_o,
  output logic                    out_valid_o,
  output logic [WORD_W-1:0]       out_data_o,
  input  logic                    out_ready_i
);
  logic              burst;
  logic              cap;
  logic              fire;
  logic [LANE_W-1:0] lane;
  logic [WORD_W-1:0] marker;

  assign out_valid_o = burst | in_valid_i;
  assign out_data_o  = burst ? marker : in_data_i;
  assign in_ready_o  = ~burst & out_ready_i;
  assign fire        = out_valid_o & out_ready_i;

  am_lane_seq #(.LANES(LANES), .PER_W(PER_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fire_i      (fire),
    .period_m1_i (period_m1_i),
    .burst_o     (burst),
    .cap_o       (cap),
    .lane_o      (lane)
  );

  am_marker_bank #(.LANES(LANES), .WORD_W(WORD_W)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cap_i     (cap),
    .markers_i (markers_i),
    .lane_i    (lane),
    .marker_o  (marker)
  );

  p_blocked_marker_held_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst && !out_ready_i |=> out_valid_o && $stable(out_data_o));
  p_no_take_in_burst_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_data_o == marker && burst |-> !in_ready_o);
endmodule

// File: tb/tb_am_inserter.sv
module tb_am_inserter;
  localparam int L = 20;
  localparam int W = 64;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic [15:0]     period_m1_i = 16'd2;
  logic [L*W-1:0]  markers_i = '0;
  logic            in_valid_i = 1'b0;
  logic [W-1:0]    in_data_i = '0;
  logic            in_ready_o;
  logic            out_valid_o;
  logic [W-1:0]    out_data_o;
  logic            out_ready_i = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk_i = ~clk_i;

  am_inserter dut (.*);

  // model state
  bit          m_burst;
  int          m_idx;
  int          m_left;
  logic [W-1:0] m_mk [L];
  bit          m_first;
  int          m_data_seen;
  int          m_bursts;
  bit          prev_blocked;
  logic [W-1:0] prev_word;

  function automatic logic [W-1:0] mk_a(int k); return 64'hA500_0000_0000_0000 | 64'(k); endfunction
  function automatic logic [W-1:0] mk_b(int k); return 64'h5B00_0000_0000_0000 | (64'(k) << 8); endfunction

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  initial begin
    #800000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=running exp=finished");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] exp_d;
    bit exp_v, exp_r, fire, use_b;
    m_burst = 1; m_idx = 0; m_left = 0; m_first = 1; m_bursts = 0;
    m_data_seen = 0; prev_blocked = 0; prev_word = '0;
    for (int k = 0; k < L; k++) m_mk[k] = '0;
    m_mk[0] = 64'hc16821003e97de00;
    m_mk[1] = 64'h9d718e00628e7100;
    for (int k = 0; k < L; k++) markers_i[k*W +: W] = mk_a(k); // R9 packing
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    for (int cyc = 0; cyc < 700; cyc++) begin
      @(negedge clk_i);
      period_m1_i = (cyc < 200) ? 16'd2 : (cyc < 300) ? 16'd0 : 16'd1;
      use_b = (cyc >= 300);
      for (int k = 0; k < L; k++) markers_i[k*W +: W] = use_b ? mk_b(k) : mk_a(k);
      out_ready_i = (cyc % 7) != 3;
      in_valid_i  = (cyc % 5) != 2;
      in_data_i   = {32'hD0D0_0000, 32'(cyc)};
      #1;
      exp_r = !m_burst && out_ready_i;
      exp_v = m_burst || in_valid_i;
      exp_d = m_burst ? m_mk[m_idx] : in_data_i;
      if (cyc == 0) begin
        chk("R1 first word is marker", {63'd0, out_valid_o}, 64'd1);
        chk("R1 lane0 reset marker", out_data_o, 64'hc16821003e97de00);
      end
      chk(m_burst ? "R3 ready low in burst" : "R5 ready follows out_ready", {63'd0, in_ready_o}, {63'd0, exp_r});
      chk(m_burst ? "R2 burst valid" : "R5 valid passthrough", {63'd0, out_valid_o}, {63'd0, exp_v});
      if (m_burst && m_first && m_idx >= 2) begin
        m_mk[m_idx] = out_data_o;   // R1: record default, checked for distinctness below
      end else if (exp_v) begin
        if (prev_blocked) chk("R6 blocked marker held", out_data_o, prev_word);
        else chk(m_burst ? (m_bursts >= 1 ? "R7 R9 active marker" : "R2 marker order")
                         : "R4 data unchanged", out_data_o, exp_d);
      end
      fire = out_valid_o && out_ready_i;
      prev_blocked = m_burst && !out_ready_i;
      prev_word = out_data_o;
      if (fire) begin
        if (m_burst) begin
          if (m_idx == L-1) begin
            if (m_first) begin
              m_first = 0;
              for (int a = 2; a < L; a++) begin
                chk("R1 default nonzero", {63'd0, m_mk[a] != 0}, 64'd1);
                for (int b = 0; b < a; b++)
                  chk("R1 defaults distinct", {63'd0, m_mk[a] != m_mk[b]}, 64'd1);
              end
            end
            if (m_bursts > 0)
              chk("R4 data words between bursts", 64'(m_data_seen), 64'(m_left));
            m_bursts++;
            for (int k = 0; k < L; k++) m_mk[k] = markers_i[k*W +: W];
            m_idx = 0;
            m_left = int'(period_m1_i) * L;
            m_data_seen = 0;
            m_burst = (m_left == 0);
            if (m_left == 0) chk("R8 zero period back to back", 64'(m_data_seen), 64'd0);
          end else m_idx++;
        end else begin
          m_data_seen++;
          if (m_data_seen == m_left) m_burst = 1;
        end
      end
    end
    chk("R7 bursts seen", {63'd0, m_bursts > 10}, 64'd1);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule